// File: doc/BRIEF.md
# Multi-Port Shared SRAM Front End

This block lets up to four requesters share one single-ported synchronous word array. Each requester raises a request, together with a read/write flag and write data. An arbiter picks exactly one requester per cycle, and that requester's access is performed on the array in the same cycle. Read data comes back on a shared data bus in the next cycle, with a per-port valid flag that marks which requester it belongs to.

Each port has a 2-bit priority rank. A higher rank wins. Among equal ranks, the next port after the most recently granted one wins, in round-robin order. A port that keeps requesting and keeps losing is promoted after a parameterized number of lost cycles, so it cannot be starved.

Each port also has its own address generator. A requester can use it to stream through a buffer without presenting an address on every access. The generator is set up through a single shared configuration write port. The array depth is a parameter: the full 16 KB configuration is `AW = 13` with 16-bit words, and the default is smaller.

Top module: `mp_shmem_front`

## Requirements
- R1: In every cycle at most one `gnt` bit is high, only for a port whose `req` bit is high. Whenever any `req` bit is high, exactly one grant is given in that same cycle.
- R2: Among requesting ports that are not promoted, a port with a strictly higher rank (`rank[2p+1:2p]`, where 3 is highest) wins over one with a lower rank.
- R3: Ties are broken round-robin. Among the tied ports, the first one found searching upward (with wrap) from the port after the most recently granted port wins. After reset the search starts at port 0.
- R4: A port that requested and was refused for `STARVE_LIM` (default 8) consecutive cycles is promoted. A promoted port wins over every unpromoted port whatever the ranks, and promoted ports tie among themselves. A port's count clears when it is granted or stops requesting.
- R5: A granted read (`we` low) raises `rvalid` for that port only, in the cycle after the grant, with the word on `rdata`. A granted write raises no `rvalid`.
- R6: A read granted in the cycle right after a write to the same address returns the newly written word, whichever ports issue the two accesses.
- R7: In direct mode (mode code 0), and also in the reserved mode code 3, the access address is the port's own slice `addr[AW*p +: AW]`.
- R8: In stride mode (code 1), the address is base plus offset. Each grant adds the step to the offset. When the sum reaches or passes the length, the offset restarts at 0. The address bus is ignored in this mode.
- R9: In circular mode (code 2), the offset advances by the step in the same way. When the sum reaches or passes the length, the length is subtracted, so the remainder is kept. A length of 0 holds the offset at 0.
- R10: A configuration write (`cfg_wr`, port chosen by `cfg_sel`) loads mode, base, step and length, and clears that port's offset to 0. An access granted to that port in the same cycle still uses the old address, and the clear takes precedence over its advance.
- R11: After reset, all ports are in direct mode, `rvalid` is all zero, and no port is promoted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NPORT | Per-port access request, held until granted |
| we | input | NPORT | Per-port write flag (1 = write) |
| rank | input | 2*NPORT | Per-port priority rank, 2 bits per port |
| addr | input | AW*NPORT | Per-port direct-mode address |
| wdata | input | DW*NPORT | Per-port write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | $clog2(NPORT) | Port whose generator is configured |
| cfg_mode | input | 2 | Address mode: 0 direct, 1 stride, 2 circular, 3 direct |
| cfg_base | input | AW | Buffer base address |
| cfg_step | input | AW | Offset increment per grant |
| cfg_len | input | AW | Buffer length in words |
| gnt | output | NPORT | One-hot grant, same cycle as the request |
| rvalid | output | NPORT | Read data valid for that port, one cycle after the grant |
| rdata | output | DW | Shared read data |

## Verification
The bench targets the round-robin pointer after ties, where a design that keeps a fixed-order tie-break would grant port 0 again instead of moving on. It targets the starvation limit: a rank-0 port facing a constant rank-3 competitor must win on exactly its ninth cycle, and an off-by-one counter shifts that win by a cycle or never promotes at all. The wrap rules are probed with a step that overshoots the length. A design that confuses stride and circular lands the fifth write at the wrong word, so a read-back at a known address shows it. A configuration write made in the same cycle as an access shows whether the access used the old address and whether the offset was cleared rather than advanced.

// File: rtl/mp_shmem_pkg.sv
package mp_shmem_pkg;

   localparam int RANK_W = 2;

   typedef enum logic [1:0] {
      AM_DIRECT = 2'd0,
      AM_STRIDE = 2'd1,
      AM_CIRC   = 2'd2,
      AM_RSVD   = 2'd3
   } amode_e;

   function automatic logic uses_offset(input amode_e m);
      return (m == AM_STRIDE) || (m == AM_CIRC);
   endfunction

endpackage

// File: rtl/mp_agen.sv
module mp_agen
   import mp_shmem_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_ld,
   input  logic [1:0]    cfg_mode,
   input  logic [AW-1:0] cfg_base,
   input  logic [AW-1:0] cfg_step,
   input  logic [AW-1:0] cfg_len,
   input  logic          adv,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out
);

   amode_e        mode_q;
   logic [AW-1:0] base_q, step_q, len_q, off_q;
   logic [AW:0]   sum, wrapped;

   always_comb begin
      sum = {1'b0, off_q} + {1'b0, step_q};
      if (sum >= {1'b0, len_q}) begin
         if (mode_q == AM_CIRC && len_q != '0) wrapped = sum - {1'b0, len_q};
         else                                  wrapped = '0;
      end else begin
         wrapped = sum;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= AM_DIRECT;
         base_q <= '0;
         step_q <= '0;
         len_q  <= '0;
         off_q  <= '0;
      end else if (cfg_ld) begin
         mode_q <= amode_e'(cfg_mode);
         base_q <= cfg_base;
         step_q <= cfg_step;
         len_q  <= cfg_len;
         off_q  <= '0;
      end else if (adv && uses_offset(mode_q)) begin
         off_q  <= wrapped[AW-1:0];
      end
   end

   assign addr_out = uses_offset(mode_q) ? base_q + off_q : addr_in;

endmodule

// File: rtl/mp_parb.sv
module mp_parb
   import mp_shmem_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int STARVE_LIM = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        req,
   input  logic [RANK_W*NPORT-1:0] rank,
   output logic [NPORT-1:0]        gnt
);

   localparam int PW = $clog2(NPORT);
   localparam int CW = $clog2(STARVE_LIM + 1);
   localparam int EW = RANK_W + 1;

   logic [PW-1:0] ptr_q;
   logic [CW-1:0] cnt_q [NPORT];
   logic [EW-1:0] eff   [NPORT];
   logic [EW-1:0] best;
   logic          found;
   int            gidx;

   // promoted ports share one level above every rank
   for (genvar p = 0; p < NPORT; p++) begin : g_eff
      assign eff[p] = (cnt_q[p] == CW'(STARVE_LIM)) ? {1'b1, {RANK_W{1'b0}}}
                                                    : {1'b0, rank[RANK_W*p +: RANK_W]};
   end

   always_comb begin
      best  = '0;
      gnt   = '0;
      found = 1'b0;
      gidx  = 0;
      for (int p = 0; p < NPORT; p++) begin
         if (req[p] && eff[p] > best) best = eff[p];
      end
      for (int i = 0; i < NPORT; i++) begin
         int idx;
         idx = (int'(ptr_q) + i) % NPORT;
         if (!found && req[idx] && eff[idx] == best) begin
            found     = 1'b1;
            gnt[idx]  = 1'b1;
            gidx      = idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (found) begin
         ptr_q <= (gidx == NPORT - 1) ? '0 : PW'(gidx + 1);
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cnt_q[p] <= '0;
         else if (!req[p] || gnt[p])  cnt_q[p] <= '0;
         else if (cnt_q[p] != CW'(STARVE_LIM)) cnt_q[p] <= cnt_q[p] + 1'b1;
      end
   end

endmodule

// File: rtl/mp_sram.sv
module mp_sram #(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          en,
   input  logic          wr,
   input  logic [AW-1:0] a,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (wr) mem[a] <= d;
         else    q      <= mem[a];
      end
   end

endmodule

// File: rtl/mp_shmem_front.sv
module mp_shmem_front
   import mp_shmem_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int AW         = 10,
   parameter int DW         = 16,
   parameter int STARVE_LIM = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORT-1:0]         req,
   input  logic [NPORT-1:0]         we,
   input  logic [RANK_W*NPORT-1:0]  rank,
   input  logic [AW*NPORT-1:0]      addr,
   input  logic [DW*NPORT-1:0]      wdata,
   input  logic                     cfg_wr,
   input  logic [$clog2(NPORT)-1:0] cfg_sel,
   input  logic [1:0]               cfg_mode,
   input  logic [AW-1:0]            cfg_base,
   input  logic [AW-1:0]            cfg_step,
   input  logic [AW-1:0]            cfg_len,
   output logic [NPORT-1:0]         gnt,
   output logic [NPORT-1:0]         rvalid,
   output logic [DW-1:0]            rdata
);

   localparam int PW = $clog2(NPORT);

   if (NPORT < 2 || NPORT > 4) begin : g_bad_nport
      $error("mp_shmem_front: NPORT must be 2..4");
   end
   if (AW < 2 || AW > 13) begin : g_bad_aw
      $error("mp_shmem_front: AW must be 2..13");
   end
   if (STARVE_LIM < 1) begin : g_bad_lim
      $error("mp_shmem_front: STARVE_LIM must be positive");
   end

   logic [AW-1:0] paddr [NPORT];
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata;
   logic          m_wr, m_en;

   mp_parb #(.NPORT(NPORT), .STARVE_LIM(STARVE_LIM)) arb_i (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req),
      .rank (rank),
      .gnt  (gnt)
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      mp_agen #(.AW(AW)) agen_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg_ld  (cfg_wr && cfg_sel == PW'(p)),
         .cfg_mode(cfg_mode),
         .cfg_base(cfg_base),
         .cfg_step(cfg_step),
         .cfg_len (cfg_len),
         .adv     (gnt[p]),
         .addr_in (addr[AW*p +: AW]),
         .addr_out(paddr[p])
      );
   end

   always_comb begin
      m_addr  = '0;
      m_wdata = '0;
      m_wr    = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
         if (gnt[p]) begin
            m_addr  = paddr[p];
            m_wdata = wdata[DW*p +: DW];
            m_wr    = we[p];
         end
      end
   end

   assign m_en = |gnt;

   mp_sram #(.AW(AW), .DW(DW)) ram_i (
      .clk(clk),
      .en (m_en),
      .wr (m_wr),
      .a  (m_addr),
      .d  (m_wdata),
      .q  (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid <= '0;
      else        rvalid <= gnt & ~we;
   end

endmodule

// File: rtl/mp_shmem_front_chk.sv
module mp_shmem_front_chk #(
   parameter int NPORT      = 4,
   parameter int STARVE_LIM = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NPORT-1:0]   req,
   input logic [NPORT-1:0]   we,
   input logic [2*NPORT-1:0] rank,
   input logic [NPORT-1:0]   gnt,
   input logic [NPORT-1:0]   rvalid
);

   localparam int BOUND = STARVE_LIM + NPORT - 1;

   int lose [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_lose
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  lose[p] <= 0;
         else if (!req[p] || gnt[p])  lose[p] <= 0;
         else if (lose[p] <= BOUND)   lose[p] <= lose[p] + 1;
      end

      // R4: a refused requester is served within the promotion window
      assert_no_starve_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lose[p] <= BOUND);

      for (genvar h = 0; h < NPORT; h++) begin : g_pair
         if (h != p) begin : g_ne
            // R2: a lower rank only wins while it has been waiting long enough
            assert_rank_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
               (gnt[p] && req[h] && rank[2*h +: 2] > rank[2*p +: 2]) |-> lose[p] >= STARVE_LIM);
         end
      end
   end

   assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_grant_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);

   assert_work_conserving_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt));

   assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gnt & ~we)) |=> rvalid == $past(gnt & ~we));

   assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(gnt & ~we)) |=> rvalid == '0);

endmodule

bind mp_shmem_front mp_shmem_front_chk #(.NPORT(NPORT), .STARVE_LIM(STARVE_LIM)) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .req   (req),
   .we    (we),
   .rank  (rank),
   .gnt   (gnt),
   .rvalid(rvalid)
);

// File: tb/mp_shmem_front_tb.sv
module mp_shmem_front_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int AW = 10;
   localparam int DW = 16;

   // vector: [15:12] req, [11:4] ranks {r3,r2,r1,r0}, [3:0] expected grant
   localparam logic [15:0] VEC [9] = '{
      16'b1111_00000000_0001,  // R3 tie, pointer at 0
      16'b1111_00000000_0010,  // R3 pointer moved to 1
      16'b0101_00000000_0100,  // R3 search from 2
      16'b0011_00001100_0010,  // R2 rank 3 beats rank 0
      16'b1001_10000001_1000,  // R2 rank 2 beats rank 1
      16'b0001_00000000_0001,  // R1 lone requester
      16'b1100_01010000_0100,  // R3 from pointer 1, p2 first
      16'b1100_01010000_1000,  // R3 then p3
      16'b0000_00000000_0000   // R1 no request no grant
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NP-1:0]       req = '0;
   logic [NP-1:0]       we = '0;
   logic [2*NP-1:0]     rank = '0;
   logic [AW*NP-1:0]    addr = '0;
   logic [DW*NP-1:0]    wdata = '0;
   logic                cfg_wr = 1'b0;
   logic [1:0]          cfg_sel = '0;
   logic [1:0]          cfg_mode = '0;
   logic [AW-1:0]       cfg_base = '0, cfg_step = '0, cfg_len = '0;
   logic [NP-1:0]       gnt, rvalid;
   logic [DW-1:0]       rdata;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mp_shmem_front #(.NPORT(NP), .AW(AW), .DW(DW), .STARVE_LIM(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .rank(rank), .addr(addr),
      .wdata(wdata), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
      .cfg_base(cfg_base), .cfg_step(cfg_step), .cfg_len(cfg_len),
      .gnt(gnt), .rvalid(rvalid), .rdata(rdata)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // one access from port p as the sole requester; grant checked in its cycle
   task automatic acc(int p, bit w, int a, int d);
      @(negedge clk);
      req = '0; we = '0;
      req[p] = 1'b1; we[p] = w;
      addr[AW*p +: AW] = AW'(a);
      wdata[DW*p +: DW] = DW'(d);
      #1 check("R1 sole grant", 32'(gnt), 32'(1 << p));
   endtask

   task automatic idle();
      @(negedge clk);
      req = '0; we = '0;
   endtask

   task automatic rd_chk(int p, int a, int exp, string tag);
      acc(p, 0, a, 0);
      idle();
      #1;
      check({tag, " rvalid"}, 32'(rvalid), 32'(1 << p));
      check({tag, " rdata"}, 32'(rdata), 32'(exp));
   endtask

   task automatic cfg(int p, int m, int b, int s, int l);
      @(negedge clk);
      req = '0; we = '0;
      cfg_wr = 1'b1; cfg_sel = 2'(p); cfg_mode = 2'(m);
      cfg_base = AW'(b); cfg_step = AW'(s); cfg_len = AW'(l);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [3:0] prev;
      repeat (3) @(negedge clk);
      #1;
      check("R11 rvalid after reset", 32'(rvalid), 0);
      check("R1 no grant when idle", 32'(gnt), 0);
      rst_n = 1'b1;

      // table walk: arbitration order, read-valid follows grant by one cycle
      prev = '0;
      foreach (VEC[i]) begin
         @(negedge clk);
         req  = VEC[i][15:12];
         rank = VEC[i][11:4];
         we   = '0;
         #1;
         check("R2/R3 table grant", 32'(gnt), 32'(VEC[i][3:0]));
         check("R5 table rvalid", 32'(rvalid), 32'(prev));
         prev = VEC[i][3:0];
      end
      idle();

      // R4: rank-0 port 1 against constant rank-3 port 0
      for (int c = 1; c <= 10; c++) begin
         @(negedge clk);
         req = 4'b0011; rank = 8'b00_00_00_11;
         #1;
         check($sformatf("R4 starvation cycle %0d", c), 32'(gnt),
               (c == 9) ? 32'b0010 : 32'b0001);
      end
      idle();
      rank = '0;

      // R6/R7: write then immediate read from another port, direct mode
      acc(0, 1, 5, 'hA5A5);
      acc(1, 0, 5, 0);
      check("R5 no rvalid after write", 32'(rvalid), 0);
      idle();
      #1;
      check("R6 fresh data valid", 32'(rvalid), 32'b0010);
      check("R6 fresh data", 32'(rdata), 'hA5A5);

      // R8: stride base 100 step 3 len 10, bus address ignored
      cfg(1, 1, 100, 3, 10);
      for (int k = 1; k <= 5; k++) acc(1, 1, 7, 'h1000 + k);
      rd_chk(0, 100, 'h1005, "R8 restart at base");
      rd_chk(0, 103, 'h1002, "R8 second step");
      rd_chk(0, 109, 'h1004, "R8 last before wrap");

      // R9: circular base 200 step 3 len 10 keeps remainder (fifth at 202)
      cfg(2, 2, 200, 3, 10);
      for (int k = 1; k <= 5; k++) acc(2, 1, 7, 'h2000 + k);
      rd_chk(0, 202, 'h2005, "R9 remainder wrap");
      rd_chk(0, 200, 'h2001, "R9 first word kept");

      // R10: configuration in the same cycle as an access
      cfg(1, 1, 300, 1, 4);
      acc(1, 1, 0, 'hAAA0);
      @(negedge clk);
      req = 4'b0010; we = 4'b0010; wdata[DW +: DW] = 'hBBB1;
      cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_mode = 2'd1;
      cfg_base = 400; cfg_step = 1; cfg_len = 4;
      #1 check("R10 grant during config", 32'(gnt), 32'b0010);
      @(negedge clk);
      cfg_wr = 1'b0; req = '0; we = '0;
      acc(1, 1, 0, 'hCCC2);
      rd_chk(0, 301, 'hBBB1, "R10 old address used");
      rd_chk(0, 400, 'hCCC2, "R10 offset cleared");

      // R7: reserved mode code 3 behaves as direct
      cfg(3, 3, 0, 0, 0);
      acc(3, 1, 50, 'h3333);
      rd_chk(0, 50, 'h3333, "R7 reserved mode direct");

      idle();
      finish_run();
   end

endmodule